// File: doc/BRIEF.md
# Retention-binned row refresh scheduler

This block decides, row by row, which rows of a DRAM device get a refresh command during each base refresh interval. Most rows hold their data for a long time. A few weak rows do not, so they are refreshed more often. Every weak row belongs to one of a small number of retention classes. Class membership is kept in compact Bloom-filter bit arrays, which keeps the storage cost far below one flag per row. A Bloom filter can report a row that was never inserted (a false positive). That costs an extra refresh but can never cause a missed one.

Software loads the filters one row at a time through an insert port. A single synchronous clear empties all of them. Each base interval tick starts a sweep over every row in ascending order. For each row, the block looks up the filters and compares the fastest matching class against the sweep index. A row that is due is presented on a valid/ready request port. A row that is not due is passed over in one cycle.

The default configuration has two weak classes, refreshed on every tick and on every second tick, and a default class refreshed on every fourth tick. With a 64 ms tick these correspond to 64 ms, 128 ms and 256 ms.

Top module: `retn_bin_refresh`

## Requirements
- R1: After reset, no request is presented, all filters are empty and the sweep index is 0. The first sweep after reset refreshes every row. The second refreshes none, unless rows have been inserted.
- R2: Each filter row index is computed in two ways. Index A is the XOR-fold of the row number: row bit b toggles index bit (b mod IDX_W). Index B is the same fold applied to the row number with its bits reversed. An insert with `ins_bin`=0 goes to the fast class (every tick). An insert with `ins_bin`=1 goes to the half-rate class. An insert sets both index bits in the chosen filter. A lookup hits only when both index bits are set, so rows whose two indices collide with inserted bits also hit.
- R3: Let k be the number of sweeps completed since reset. A row is due in sweep k under any of these conditions: it hits the fast filter; it hits the half-rate filter and k is even; k mod 4 is 0. The fastest matching class wins.
- R4: A `period_tick` starts a sweep of rows 0 to 2^ROW_W-1. Requests are issued in ascending row order. Each due row is requested exactly once, and no other row is requested.
- R5: While `ref_valid` is high and `ref_ready` is low, the request stays valid and `ref_row` does not change.
- R6: A row that is not due takes one cycle. Each row takes one evaluation cycle before its request appears. After a tick is sampled, a first due row r is presented r+1 cycles later. A completed handshake is always followed by one cycle with `ref_valid` low.
- R7: A tick that arrives while a sweep is running is held. The next sweep starts immediately after the current one ends. Any number of ticks during one sweep collapse into a single pending sweep.
- R8: `filt_clear` zeroes every filter on the next clock edge. After that, every row falls into the default class until new inserts arrive.
- R9: When `filt_clear` and `ins_valid` are high in the same cycle, the clear wins and the insert is lost.

Ports are listed in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_tick | input | 1 | One-cycle pulse for each base refresh interval |
| filt_clear | input | 1 | Synchronous clear of all filters |
| ins_valid | input | 1 | Insert `ins_row` into the filter chosen by `ins_bin` |
| ins_bin | input | BIN_W | Class to insert into; 0 is the fastest |
| ins_row | input | ROW_W | Row number to insert |
| ref_ready | input | 1 | Downstream accepts the refresh request |
| ref_valid | output | 1 | A refresh request is pending |
| ref_row | output | ROW_W | Row to refresh |

## Verification
The bench walks the sweep index through every residue modulo 4 with a filter load that deliberately produces false positives. A design that matched on one index only, or chose the wrong class for a row in both filters, would issue the wrong number of requests. It measures the tick-to-first-request latency for a first due row of 0 and of 5. A block that spent more than one cycle on skipped rows, or dropped the evaluation cycle, shifts that count. It stalls a request for many cycles to catch a row or valid that moves. It fires three ticks into one sweep and expects exactly one follow-up sweep: a design that dropped the pending tick, or counted all three, is off by a full sweep. It also issues a clear together with an insert, so a design that let the insert win would refresh row 9 on odd sweeps.

// File: rtl/rbr_pkg.sv
package rbr_pkg;

    // Sweep controller states
    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_EVAL = 2'd1,
        SW_REQ  = 2'd2
    } sweep_st_e;

endpackage

// File: rtl/rbr_hash.sv
// Two filter indices per row: fold of the row, fold of the bit-reversed row.
module rbr_hash #(
    parameter int ROW_W = 12,
    parameter int IDX_W = 10
) (
    input  logic [ROW_W-1:0] row_i,
    output logic [IDX_W-1:0] idx_a_o,
    output logic [IDX_W-1:0] idx_b_o
);
    localparam int SLICES = (ROW_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = SLICES * IDX_W;

    logic [ROW_W-1:0] row_rev;
    logic [PAD_W-1:0] fwd_pad;
    logic [PAD_W-1:0] rev_pad;

    always_comb begin
        for (int i = 0; i < ROW_W; i++) begin
            row_rev[i] = row_i[ROW_W-1-i];
        end
        fwd_pad = PAD_W'(row_i);
        rev_pad = PAD_W'(row_rev);
        idx_a_o = '0;
        idx_b_o = '0;
        for (int s = 0; s < SLICES; s++) begin
            idx_a_o = idx_a_o ^ fwd_pad[s*IDX_W +: IDX_W];
            idx_b_o = idx_b_o ^ rev_pad[s*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/rbr_bloom.sv
// One retention-class membership filter.
module rbr_bloom #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             ins_en_i,
    input  logic [IDX_W-1:0] ins_a_i,
    input  logic [IDX_W-1:0] ins_b_i,
    input  logic [IDX_W-1:0] look_a_i,
    input  logic [IDX_W-1:0] look_b_i,
    output logic             hit_o
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0] bits;
    } bloom_t;

    bloom_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.bits = '0;           // clear beats a same-cycle insert
        end else if (ins_en_i) begin
            st_d.bits[ins_a_i] = 1'b1;
            st_d.bits[ins_b_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_o = st_q.bits[look_a_i] & st_q.bits[look_b_i];
endmodule

// File: rtl/rbr_sweep.sv
// Row walker: one sweep per tick, one pending tick remembered.
module rbr_sweep
    import rbr_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int PH_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             due_i,
    input  logic             ready_i,
    output logic [ROW_W-1:0] row_o,
    output logic             valid_o,
    output logic [PH_W-1:0]  phase_o,
    output sweep_st_e        state_o
);
    typedef struct packed {
        sweep_st_e        st;
        logic [ROW_W-1:0] row;
        logic [PH_W-1:0]  phase;
        logic             pend;
    } sweep_t;

    sweep_t st_d, st_q;
    logic   advance;
    logic   restart;
    logic   last_row;

    always_comb begin
        st_d     = st_q;
        advance  = 1'b0;
        restart  = st_q.pend | tick_i;
        last_row = &st_q.row;

        if (tick_i && st_q.st != SW_IDLE) st_d.pend = 1'b1;

        case (st_q.st)
            SW_IDLE: begin
                if (tick_i) begin
                    st_d.st  = SW_EVAL;
                    st_d.row = '0;
                end
            end
            SW_EVAL: begin
                if (due_i) st_d.st = SW_REQ;
                else       advance = 1'b1;
            end
            SW_REQ: begin
                if (ready_i) advance = 1'b1;
            end
            default: st_d.st = SW_IDLE;
        endcase

        if (advance) begin
            if (!last_row) begin
                st_d.row = st_q.row + 1'b1;
                st_d.st  = SW_EVAL;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
                if (restart) begin
                    st_d.st   = SW_EVAL;
                    st_d.row  = '0;
                    st_d.pend = 1'b0;
                end else begin
                    st_d.st = SW_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st    <= SW_IDLE;
            st_q.row   <= '0;
            st_q.phase <= '0;
            st_q.pend  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_o   = st_q.row;
    assign valid_o = (st_q.st == SW_REQ);
    assign phase_o = st_q.phase;
    assign state_o = st_q.st;
endmodule

// File: rtl/retn_bin_refresh.sv
module retn_bin_refresh
    import rbr_pkg::*;
#(
    parameter int ROW_W    = 12,
    parameter int IDX_W    = 10,
    parameter int NUM_WEAK = 2,
    localparam int BIN_W   = (NUM_WEAK > 1) ? $clog2(NUM_WEAK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_tick,
    input  logic             filt_clear,
    input  logic             ins_valid,
    input  logic [BIN_W-1:0] ins_bin,
    input  logic [ROW_W-1:0] ins_row,
    input  logic             ref_ready,
    output logic             ref_valid,
    output logic [ROW_W-1:0] ref_row
);
    localparam int PH_W = NUM_WEAK;

    logic [IDX_W-1:0]    ins_a, ins_b, look_a, look_b;
    logic [NUM_WEAK-1:0] hit_vec;
    logic [ROW_W-1:0]    sw_row;
    logic [PH_W-1:0]     sw_phase;
    sweep_st_e           sw_state;
    logic                row_due;

    rbr_hash #(.ROW_W(ROW_W), .IDX_W(IDX_W)) u_hash_ins (
        .row_i   (ins_row),
        .idx_a_o (ins_a),
        .idx_b_o (ins_b)
    );

    rbr_hash #(.ROW_W(ROW_W), .IDX_W(IDX_W)) u_hash_look (
        .row_i   (sw_row),
        .idx_a_o (look_a),
        .idx_b_o (look_b)
    );

    for (genvar g = 0; g < NUM_WEAK; g++) begin : g_bin
        logic ins_en;
        assign ins_en = ins_valid && (ins_bin == BIN_W'(g));
        rbr_bloom #(.IDX_W(IDX_W)) u_bloom (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (filt_clear),
            .ins_en_i (ins_en),
            .ins_a_i  (ins_a),
            .ins_b_i  (ins_b),
            .look_a_i (look_a),
            .look_b_i (look_b),
            .hit_o    (hit_vec[g])
        );
    end

    // Class i repeats every 2^i sweeps; the default class every 2^NUM_WEAK.
    always_comb begin
        row_due = (sw_phase == '0);
        for (int i = 0; i < NUM_WEAK; i++) begin
            if (hit_vec[i] && ((sw_phase & PH_W'((1 << i) - 1)) == '0)) begin
                row_due = 1'b1;
            end
        end
    end

    rbr_sweep #(.ROW_W(ROW_W), .PH_W(PH_W)) u_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (period_tick),
        .due_i   (row_due),
        .ready_i (ref_ready),
        .row_o   (sw_row),
        .valid_o (ref_valid),
        .phase_o (sw_phase),
        .state_o (sw_state)
    );

    assign ref_row = sw_row;
endmodule

// File: rtl/rbr_chk.sv
module rbr_chk
    import rbr_pkg::*;
#(
    parameter int ROW_W    = 12,
    parameter int NUM_WEAK = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                period_tick,
    input logic                filt_clear,
    input logic                ref_valid,
    input logic                ref_ready,
    input logic [ROW_W-1:0]    ref_row,
    input logic [NUM_WEAK-1:0] hit_vec,
    input sweep_st_e           sw_state,
    input logic [ROW_W-1:0]    sw_row
);
    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid && !ref_ready |=> ref_valid);

    // R5
    req_row_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid && !ref_ready |=> $stable(ref_row));

    // R6
    req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid && ref_ready |=> !ref_valid);

    // R8
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        filt_clear |=> hit_vec == '0);

    // R7
    tick_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_tick && sw_state == SW_IDLE |=> sw_state == SW_EVAL && sw_row == '0);
endmodule

bind retn_bin_refresh rbr_chk #(.ROW_W(ROW_W), .NUM_WEAK(NUM_WEAK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .period_tick (period_tick),
    .filt_clear  (filt_clear),
    .ref_valid   (ref_valid),
    .ref_ready   (ref_ready),
    .ref_row     (ref_row),
    .hit_vec     (hit_vec),
    .sw_state    (sw_state),
    .sw_row      (sw_row)
);

// File: tb/retn_bin_refresh_tb_top.sv
`timescale 1ns/1ps
module retn_bin_refresh_tb_top;
    localparam int ROW_W = 6;
    localparam int IDX_W = 10;
    localparam int NROWS = 1 << ROW_W;
    localparam int SWEEP_WAIT = 1200;

    typedef struct packed {
        logic [1:0] rmode;     // 0 ready high, 1 toggling, 2 pseudo-random
        logic [7:0] exp_total; // requests expected in the sweep
    } vec_t;

    // sweeps 2..9 after the filter load
    localparam vec_t VECS [8] = '{
        '{2'd0, 8'd6},  '{2'd1, 8'd4},  '{2'd2, 8'd64}, '{2'd0, 8'd4},
        '{2'd2, 8'd6},  '{2'd1, 8'd4},  '{2'd1, 8'd64}, '{2'd2, 8'd4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic period_tick = 1'b0;
    logic filt_clear = 1'b0;
    logic ins_valid = 1'b0;
    logic [0:0] ins_bin = '0;
    logic [ROW_W-1:0] ins_row = '0;
    logic ref_ready = 1'b0;
    logic ref_valid;
    logic [ROW_W-1:0] ref_row;

    always #2.5 clk = ~clk;

    retn_bin_refresh #(.ROW_W(ROW_W), .IDX_W(IDX_W), .NUM_WEAK(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .period_tick(period_tick),
        .filt_clear(filt_clear), .ins_valid(ins_valid), .ins_bin(ins_bin),
        .ins_row(ins_row), .ref_ready(ref_ready), .ref_valid(ref_valid),
        .ref_row(ref_row)
    );

    int n_checks = 0;
    int n_fail = 0;
    int rmode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [IDX_W-1:0] dummy;
    logic [(1<<IDX_W)-1:0] mdl [2];

    // monitor: sole writer of the counters below
    int cnt [NROWS];
    int tot_req = 0;
    int ord_err = 0;
    int last_row = -1;
    int sweep_id = 0;
    int seen_id = 0;
    int ord_on = 1;

    always @(negedge clk) begin
        if (seen_id != sweep_id) begin
            seen_id = sweep_id;
            last_row = -1;
        end
        if (rst_n && ref_valid && ref_ready) begin
            cnt[ref_row] = cnt[ref_row] + 1;
            tot_req = tot_req + 1;
            if (ord_on != 0 && int'(ref_row) <= last_row) ord_err = ord_err + 1;
            last_row = int'(ref_row);
        end
    end

    function automatic int idx_a(int r);
        int acc = 0;
        for (int b = 0; b < ROW_W; b++)
            if (r[b]) acc = acc ^ (1 << (b % IDX_W));
        return acc;
    endfunction

    function automatic int idx_b(int r);
        int acc = 0;
        for (int b = 0; b < ROW_W; b++)
            if (r[ROW_W-1-b]) acc = acc ^ (1 << (b % IDX_W));
        return acc;
    endfunction

    function automatic bit mdl_hit(int bin, int r);
        return mdl[bin][idx_a(r)] && mdl[bin][idx_b(r)];
    endfunction

    function automatic bit mdl_due(int r, int k);
        return mdl_hit(0, r) || (mdl_hit(1, r) && (k % 2 == 0)) || (k % 4 == 0);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive_ready();
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (rmode)
                0: ref_ready = 1'b1;
                1: ref_ready = ~ref_ready;
                2: ref_ready = lfsr[0];
                default: ref_ready = 1'b0;
            endcase
        end
    endtask

    task automatic pulse_tick();
        @(posedge clk); #1 period_tick = 1'b1;
        @(posedge clk); #1 period_tick = 1'b0;
    endtask

    task automatic insert(input int bin, input int r);
        @(posedge clk); #1;
        ins_valid = 1'b1; ins_bin = 1'(bin); ins_row = ROW_W'(r);
        @(posedge clk); #1;
        ins_valid = 1'b0;
        mdl[bin][idx_a(r)] = 1'b1;
        mdl[bin][idx_b(r)] = 1'b1;
    endtask

    // R3 per row, R4 totals and order
    task automatic check_rows(input int base [NROWS], input int base_tot, input int base_ord,
                              input int k0, input int nsw, input int exp_tot);
        int exp_sum = 0;
        for (int r = 0; r < NROWS; r++) begin
            int e = 0;
            for (int j = 0; j < nsw; j++) e += int'(mdl_due(r, k0 + j));
            exp_sum += e;
            check(cnt[r] - base[r] == e, $sformatf("R3 sweep %0d row %0d", k0, r), cnt[r] - base[r], e);
        end
        check(tot_req - base_tot == exp_tot, $sformatf("R4 total sweep %0d", k0), tot_req - base_tot, exp_tot);
        check(exp_sum == exp_tot, $sformatf("R4 table sweep %0d", k0), exp_sum, exp_tot);
        check(ord_err - base_ord == 0, $sformatf("R4 order sweep %0d", k0), ord_err - base_ord, 0);
    endtask

    task automatic run_sweep(input int k, input int exp_tot);
        int base [NROWS];
        int bt, bo;
        base = cnt; bt = tot_req; bo = ord_err;
        sweep_id++;
        pulse_tick();
        repeat (SWEEP_WAIT) @(posedge clk);
        #1;
        check_rows(base, bt, bo, k, 1, exp_tot);
    endtask

    // R6: cycles from sampled tick to first request
    task automatic lat_sweep(input int k, input int exp_n, input int exp_tot);
        int base [NROWS];
        int bt, bo, n;
        base = cnt; bt = tot_req; bo = ord_err;
        sweep_id++;
        rmode = 0;
        @(posedge clk); #1 period_tick = 1'b1;
        @(posedge clk); #1 period_tick = 1'b0;
        n = 0;
        while (!ref_valid && n < 200) begin
            @(posedge clk); #1;
            n++;
        end
        check(n == exp_n, $sformatf("R6 latency sweep %0d", k), n, exp_n);
        repeat (SWEEP_WAIT) @(posedge clk);
        #1;
        check_rows(base, bt, bo, k, 1, exp_tot);
    endtask

    initial begin
        #750000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int base [NROWS];
        int bt, bo;
        for (int r = 0; r < NROWS; r++) cnt[r] = 0;
        mdl[0] = '0; mdl[1] = '0;
        fork drive_ready(); join_none
        repeat (4) @(posedge clk);
        #1;
        check(ref_valid == 1'b0, "R1 valid in reset", int'(ref_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(ref_valid == 1'b0, "R1 valid after reset", int'(ref_valid), 0);

        // R1: empty filters, sweep index 0 then 1
        run_sweep(0, 64);
        run_sweep(1, 0);

        // R2: load with collisions; 40 and 34 become false hits in the fast filter
        insert(0, 5);
        insert(0, 17);
        insert(1, 9);
        insert(1, 40);
        insert(1, 17);

        for (int v = 0; v < 8; v++) begin
            rmode = int'(VECS[v].rmode);
            run_sweep(2 + v, int'(VECS[v].exp_total));
        end

        lat_sweep(10, 6, 6);   // first due row 5
        lat_sweep(11, 6, 4);
        lat_sweep(12, 1, 64);  // first due row 0

        // R5: stall the first request of sweep 13
        base = cnt; bt = tot_req; bo = ord_err;
        sweep_id++;
        rmode = 3;
        pulse_tick();
        repeat (30) @(posedge clk);
        #1;
        check(ref_valid == 1'b1, "R5 valid held under stall", int'(ref_valid), 1);
        check(ref_row == ROW_W'(5), "R5 row held under stall", int'(ref_row), 5);
        rmode = 0;
        repeat (SWEEP_WAIT) @(posedge clk);
        #1;
        check_rows(base, bt, bo, 13, 1, 4);

        // R7: three ticks during one sweep give exactly one extra sweep
        base = cnt; bt = tot_req; bo = ord_err;
        ord_on = 0;
        sweep_id++;
        rmode = 2;
        pulse_tick();
        pulse_tick();
        pulse_tick();
        repeat (3 * SWEEP_WAIT) @(posedge clk);
        #1;
        check_rows(base, bt, bo, 14, 2, 10);
        ord_on = 1;

        // R9: clear and insert in the same cycle; R8: all rows default afterwards
        @(posedge clk); #1;
        filt_clear = 1'b1; ins_valid = 1'b1; ins_bin = 1'b0; ins_row = ROW_W'(9);
        @(posedge clk); #1;
        filt_clear = 1'b0; ins_valid = 1'b0;
        mdl[0] = '0; mdl[1] = '0;
        rmode = 0;
        run_sweep(16, 64);
        run_sweep(17, 0);   // R9: a surviving insert of row 9 would show here
        run_sweep(18, 0);
        run_sweep(19, 0);

        // R2 after clear: half-rate insert of row 9 also hits row 36
        insert(1, 9);
        run_sweep(20, 64);
        run_sweep(21, 0);
        run_sweep(22, 2);

        dummy = '0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule